// File: doc/BRIEF.md
# Regulator Low-Power Mode Controller

This block sits between software and the core voltage regulator and steps the regulator between its main mode and its low-power mode. Software writes a control register holding a low-power request bit and an optional flash power-down bit, and polls a status register whose low-power flag shows whether the regulator is still in, or still leaving, low-power operation. The block drives a regulator mode select line and a flash power-down line. It reads back a regulator-ready indication and a flag that says the system clock is currently above 2 MHz.

Entry happens as soon as a legal request is stored. A request made while the clock is still fast is refused and reported through an error bit. Leaving low-power mode is a handshake. Clearing the request drops the mode select and releases the flash at once. The status flag stays set until the regulator has reported ready for a programmable number of consecutive cycles, which stands in for its wakeup time. Software waits for that flag before it raises the clock again. Pin states elsewhere on the chip are not touched by any of this.

Top module: `reglp_ctrl`

## Requirements
- R1: After a synchronous reset, reg_lp_sel, flash_pd, the stored request and flash bits, the status flag, the error bit and bus_rdata are all 0.
- R2: A write to address 0 with bit 0 = 1, made in main mode while clk_fast = 0, stores the request. reg_lp_sel and the status flag (status bit 0) both go to 1 one clock edge after the request is stored.
- R3: A write to address 0 with bit 0 = 1, made in main mode while clk_fast = 1, leaves the request bit at 0 and reg_lp_sel at 0, and sets the error bit (status bit 1).
- R4: Every write to address 0 recomputes the error bit. It becomes 1 only for a refused entry as in R3, so any other control write clears it.
- R5: Writing bit 0 = 0 while in low-power mode starts the exit. On the edge after the cleared request is stored, reg_lp_sel and flash_pd both drop to 0 while the status flag stays 1.
- R6: During exit, the status flag clears on the edge where reg_ready has been high on WAKE_CYC consecutive edges counted within the exit. Any edge with reg_ready low restarts the count.
- R7: flash_pd equals the stored flash bit (control bit 1) while in low-power mode, with one edge of latency, and is 0 outside it. The stored bit itself is kept.
- R8: During exit, a write of bit 0 = 1 is ignored. The request bit reads 0, the exit continues and the error bit is not set.
- R9: bus_rdata is registered. The edge after an address is presented it returns {control bit 1 flash, bit 0 request} for address 0, {bit 1 error, bit 0 flag} for address 1, and 0 for any other address. Writes to any address other than 0 change nothing.
- R10: reg_ready has no effect outside the exit phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address (0 control, 1 status) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| clk_fast | input | 1 | High while the system clock is above 2 MHz |
| reg_ready | input | 1 | Regulator reports main-mode operation |
| reg_lp_sel | output | 1 | Regulator mode select, 1 = low-power |
| flash_pd | output | 1 | Flash power-down request |

## Verification
Entry is attempted once with the clock-fast flag high and once with it low. This separates a refused request, which sets only the error bit, from an accepted one that moves the mode select. The exit is first run with reg_ready held low, which shows that the flag does not clear on a timer alone. It is then run with a ready burst broken by one low cycle, which shows that the count restarts, and finally with ready held high from the start, which pins the exact edge on which the flag clears. Writes made during the exit and writes to unused addresses are read back to show they change nothing.

// File: rtl/reglp_pkg.sv
package reglp_pkg;
  typedef enum logic [1:0] {
    ST_MAIN = 2'd0,
    ST_LP   = 2'd1,
    ST_EXIT = 2'd2
  } reglp_state_t;

  localparam int ADDR_CTRL = 0;
  localparam int ADDR_STAT = 1;
  localparam int BIT_LP    = 0;
  localparam int BIT_FPD   = 1;
  localparam int BIT_FLAG  = 0;
  localparam int BIT_ERR   = 1;
endpackage

// File: rtl/reglp_regs.sv
module reglp_regs
  import reglp_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              clk_fast,
  input  reglp_state_t      state,
  input  logic              flag,
  output logic              lp_req,
  output logic              fpd_req,
  output logic [DATA_W-1:0] rdata
);
  logic              wr_ctrl;
  logic              lp_accept;
  logic              lp_q, fpd_q, err_q;
  logic [DATA_W-1:0] rd_mux, rdata_q;
  logic              unused_hi;

  assign wr_ctrl   = wr_en && (addr == ADDR_W'(ADDR_CTRL));
  assign unused_hi = ^wdata;

  // A set request is taken only from main mode at a slow clock, or kept in low-power mode
  assign lp_accept = wdata[BIT_LP] &&
                     (((state == ST_MAIN) && !clk_fast) || (state == ST_LP));

  always_comb begin
    rd_mux = '0;
    if (addr == ADDR_W'(ADDR_CTRL)) begin
      rd_mux[BIT_LP]  = lp_q;
      rd_mux[BIT_FPD] = fpd_q;
    end else if (addr == ADDR_W'(ADDR_STAT)) begin
      rd_mux[BIT_FLAG] = flag;
      rd_mux[BIT_ERR]  = err_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lp_q    <= 1'b0;
      fpd_q   <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (wr_ctrl) begin
        lp_q  <= lp_accept;
        fpd_q <= wdata[BIT_FPD];
        err_q <= (state == ST_MAIN) && wdata[BIT_LP] && clk_fast;
      end
      rdata_q <= rd_mux;
    end
  end

  assign lp_req  = lp_q;
  assign fpd_req = fpd_q;
  assign rdata   = rdata_q;

  AST_REFUSE_FAST: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && wdata[BIT_LP] && clk_fast && (state == ST_MAIN)) |=> (!lp_req && rdata_q == rdata_q && err_q)); // R3
  AST_EXIT_NO_REENTRY: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && (state == ST_EXIT)) |=> (!lp_req && !err_q)); // R8
endmodule

// File: rtl/reglp_wake_timer.sv
module reglp_wake_timer #(
  parameter int WAKE_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic ready,
  output logic done
);
  localparam int CNT_W = (WAKE_CYC > 1) ? $clog2(WAKE_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WAKE_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign done = run && ready && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (!run || !ready || done) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt_q == '0)); // R10
endmodule

// File: rtl/reglp_seq.sv
module reglp_seq
  import reglp_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         lp_req,
  input  logic         fpd_req,
  input  logic         wake_done,
  input  logic         reg_ready,
  output reglp_state_t state,
  output logic         flag,
  output logic         reg_lp_sel,
  output logic         flash_pd
);
  reglp_state_t state_q, state_nxt;
  logic         sel_q, fpd_q, flag_q;

  always_comb begin
    state_nxt = state_q;
    case (state_q)
      ST_MAIN: if (lp_req)    state_nxt = ST_LP;
      ST_LP:   if (!lp_req)   state_nxt = ST_EXIT;
      ST_EXIT: if (wake_done) state_nxt = ST_MAIN;
      default:                state_nxt = ST_MAIN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_MAIN;
      sel_q   <= 1'b0;
      fpd_q   <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      state_q <= state_nxt;
      sel_q   <= (state_nxt == ST_LP);
      fpd_q   <= (state_nxt == ST_LP) && fpd_req;
      flag_q  <= (state_nxt != ST_MAIN);
    end
  end

  assign state      = state_q;
  assign flag       = flag_q;
  assign reg_lp_sel = sel_q;
  assign flash_pd   = fpd_q;

  AST_SEL_HAS_FLAG: assert property (@(posedge clk) disable iff (rst)
    reg_lp_sel |-> flag); // R2
  AST_FPD_IN_LP: assert property (@(posedge clk) disable iff (rst)
    flash_pd |-> reg_lp_sel); // R7
  AST_EXIT_KEEPS_FLAG: assert property (@(posedge clk) disable iff (rst)
    $fell(reg_lp_sel) |-> (flag && !flash_pd)); // R5
  AST_FLAG_CLEARS_ON_READY: assert property (@(posedge clk) disable iff (rst)
    $fell(flag) |-> $past(reg_ready)); // R6
endmodule

// File: rtl/reglp_ctrl.sv
module reglp_ctrl
  import reglp_pkg::*;
#(
  parameter int ADDR_W   = 2,
  parameter int DATA_W   = 8,
  parameter int WAKE_CYC = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              clk_fast,
  input  logic              reg_ready,
  output logic              reg_lp_sel,
  output logic              flash_pd
);
  reglp_state_t state;
  logic         flag, lp_req, fpd_req, wake_done;

  reglp_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (bus_wr),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .clk_fast (clk_fast),
    .state    (state),
    .flag     (flag),
    .lp_req   (lp_req),
    .fpd_req  (fpd_req),
    .rdata    (bus_rdata)
  );

  reglp_wake_timer #(.WAKE_CYC(WAKE_CYC)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .run   (state == ST_EXIT),
    .ready (reg_ready),
    .done  (wake_done)
  );

  reglp_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .lp_req     (lp_req),
    .fpd_req    (fpd_req),
    .wake_done  (wake_done),
    .reg_ready  (reg_ready),
    .state      (state),
    .flag       (flag),
    .reg_lp_sel (reg_lp_sel),
    .flash_pd   (flash_pd)
  );
endmodule

// File: tb/reglp_ctrl_bench.sv
module reglp_ctrl_bench;
  localparam int WAKE = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd1;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       clk_fast = 1'b0;
  logic       reg_ready = 1'b0;
  logic       reg_lp_sel, flash_pd;

  int checks = 0;
  int fails  = 0;
  bit done_run = 1'b0;

  always #5 clk = ~clk;

  reglp_ctrl #(.ADDR_W(2), .DATA_W(8), .WAKE_CYC(WAKE)) u_reglp_ctrl (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .clk_fast(clk_fast),
    .reg_ready(reg_ready), .reg_lp_sel(reg_lp_sel), .flash_pd(flash_pd)
  );

  // Behavioural reference: mode 0 main, 1 low-power, 2 exiting
  int   m_mode = 0, m_cnt = 0;
  bit   m_lp = 0, m_fpd = 0, m_err = 0, m_sel = 0, m_fout = 0, m_flag = 0;
  logic [7:0] m_rdata = 8'd0;

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 0; m_cnt = 0; m_lp = 0; m_fpd = 0; m_err = 0;
      m_sel = 0; m_fout = 0; m_flag = 0; m_rdata = 8'd0;
    end else begin
      int  nmode, ncnt;
      bit  nlp, nfpd, nerr;
      nlp = m_lp; nfpd = m_fpd; nerr = m_err;
      if (bus_wr && bus_addr == 2'd0) begin
        nfpd = bus_wdata[1];
        nerr = (m_mode == 0) && bus_wdata[0] && clk_fast;
        if (!bus_wdata[0])   nlp = 0;
        else if (m_mode == 0) nlp = !clk_fast;
        else if (m_mode == 1) nlp = 1;
        else                  nlp = 0;
      end
      if (m_mode == 0)      nmode = m_lp ? 1 : 0;
      else if (m_mode == 1) nmode = m_lp ? 1 : 2;
      else                  nmode = (reg_ready && m_cnt == WAKE - 1) ? 0 : 2;
      ncnt = (m_mode == 2 && reg_ready && m_cnt < WAKE - 1) ? m_cnt + 1 : 0;
      case (bus_addr)
        2'd0:    m_rdata = {6'd0, m_fpd, m_lp};
        2'd1:    m_rdata = {6'd0, m_err, m_flag};
        default: m_rdata = 8'd0;
      endcase
      m_fout = (nmode == 1) && m_fpd;
      m_sel  = (nmode == 1);
      m_flag = (nmode != 0);
      m_mode = nmode; m_cnt = ncnt; m_lp = nlp; m_fpd = nfpd; m_err = nerr;
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    if (!rst && !done_run) begin
      check("R2 mode select vs model", {7'd0, reg_lp_sel}, {7'd0, m_sel});
      check("R7 flash power-down vs model", {7'd0, flash_pd}, {7'd0, m_fout});
      check("R9 read data vs model", bus_rdata, m_rdata);
    end
  end

  task automatic wr(input logic [1:0] a, input bit lp, input bit fpd);
    @(negedge clk);
    bus_addr = a; bus_wdata = {6'd0, fpd, lp}; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 2'd1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset select", {7'd0, reg_lp_sel}, 8'd0);
    check("R1 reset flash", {7'd0, flash_pd}, 8'd0);
    check("R1 reset status", bus_rdata, 8'd0);

    // Refused entry at a fast clock
    clk_fast = 1'b1;
    wr(2'd0, 1, 1);
    idle(3);
    check("R3 select stays main", {7'd0, reg_lp_sel}, 8'd0);
    check("R3 status error set", bus_rdata, 8'h02);
    bus_addr = 2'd0; idle(2);
    check("R3 request not stored", bus_rdata, 8'h02);
    bus_addr = 2'd1;

    // Accepted entry at a slow clock, no flash power-down
    clk_fast = 1'b0;
    wr(2'd0, 1, 0);
    idle(3);
    check("R2 select low-power", {7'd0, reg_lp_sel}, 8'd1);
    check("R4 error cleared, flag set", bus_rdata, 8'h01);
    check("R7 flash stays on", {7'd0, flash_pd}, 8'd0);

    wr(2'd0, 1, 1);
    idle(3);
    check("R7 flash powered down", {7'd0, flash_pd}, 8'd1);

    reg_ready = 1'b1; idle(WAKE + 3);
    check("R10 ready ignored in low-power", {7'd0, reg_lp_sel}, 8'd1);
    reg_ready = 1'b0;

    // Exit with ready low: flag must hold
    wr(2'd0, 0, 1);
    idle(2);
    check("R5 select dropped", {7'd0, reg_lp_sel}, 8'd0);
    check("R5 flash released", {7'd0, flash_pd}, 8'd0);
    idle(WAKE + 4);
    check("R6 flag held without ready", bus_rdata, 8'h01);

    wr(2'd0, 1, 1);
    bus_addr = 2'd0; idle(2);
    check("R8 request ignored in exit", bus_rdata, 8'h02);
    bus_addr = 2'd1; idle(2);
    check("R8 exit continues, no error", bus_rdata, 8'h01);
    check("R8 select stays main", {7'd0, reg_lp_sel}, 8'd0);

    // Broken ready burst restarts the count
    reg_ready = 1'b1; idle(WAKE - 2);
    reg_ready = 1'b0; idle(1);
    reg_ready = 1'b1; idle(WAKE - 2);
    check("R6 flag held after restart", bus_rdata, 8'h01);
    idle(4);
    check("R6 flag cleared", bus_rdata, 8'h00);
    reg_ready = 1'b0;

    // Write to an unused address changes nothing
    wr(2'd2, 1, 0);
    idle(3);
    check("R9 unused write no entry", {7'd0, reg_lp_sel}, 8'd0);
    bus_addr = 2'd0; idle(2);
    check("R9 control kept", bus_rdata, 8'h02);
    bus_addr = 2'd3; idle(2);
    check("R9 unused address reads 0", bus_rdata, 8'h00);
    bus_addr = 2'd1;

    // Second round with ready already high
    reg_ready = 1'b1;
    wr(2'd0, 1, 1);
    idle(4);
    check("R7 flash down again", {7'd0, flash_pd}, 8'd1);
    wr(2'd0, 0, 0);
    idle(WAKE + 4);
    check("R6 flag cleared with steady ready", bus_rdata, 8'h00);
    check("R1 back to main select", {7'd0, reg_lp_sel}, 8'd0);

    done_run = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule